// File: doc/BRIEF.md
# Dual-Mode Bus Grant Arbiter

This block decides which of five masters may drive a shared bus. The local host bridge is one of the five. The other four are external devices. A run-time mode input chooses between two schemes. The first is strict fixed priority. The second demotes the most recent real owner to the bottom of the ranking while the other masters keep their fixed order. The block acts only while host mode is enabled. Otherwise it grants nothing.

Grants change only at clock edges where the bus is reported idle. At an idle edge with no request pending, the bus is parked on the host bridge. The controller has three states:

- `ST_OFF`: no grant is driven.
- `ST_PARK`: the host bridge is granted by default.
- `ST_OWN`: a requesting master holds the bus.

The state changes at an edge as follows:

- Disable: from any state to `ST_OFF` when host mode is low.
- Award: from any state to `ST_OWN` at an idle edge with at least one request.
- Park: from any state to `ST_PARK` at an idle edge with no request.
- Hold: the current state stays when the bus is busy.

Top module: `bus_grant_arbiter`

## Requirements
- R1: Bit positions in `req_i` and `gnt_o` are 0 for the host bridge and 1 to 4 for devices 0 to 3. `gnt_o` has at most one bit set in any cycle.
- R2: With `rr_mode_i`=0, an idle edge in host mode grants the lowest-numbered requesting bit.
- R3: With `rr_mode_i`=1, the last real owner ranks lowest and the other requesters keep lowest-index-first order. The owner is granted again only when no other master requests.
- R4: At any edge with `host_en_i`=0, `gnt_o` becomes 0 whatever `req_i` and `rr_mode_i` are. Once enabled again, the first grant waits for an idle edge.
- R5: At an edge with `bus_idle_i`=0, `gnt_o` keeps its value. Changes of `req_i` or `rr_mode_i` in such cycles take effect only at the next idle edge.
- R6: The demotion record changes only when a requesting master is granted. Parking and disabled cycles leave it unchanged.
- R7: At an idle edge in host mode with `req_i`=0, `gnt_o` becomes 5'b00001 (parked on the host bridge).
- R8: Reset clears `gnt_o` to 0 and clears the demotion record. The first decision after reset therefore follows fixed order even with `rr_mode_i`=1.
- R9: A non-park grant always goes to a master whose request bit was set at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request per master, bit 0 is the host bridge |
| bus_idle_i | input | 1 | High when no transfer is in flight and ownership may change |
| rr_mode_i | input | 1 | 0 selects fixed priority, 1 selects owner demotion |
| host_en_i | input | 1 | High when the bridge runs in host mode |
| gnt_o | output | 5 | One-hot grant, same bit order as `req_i` |

## Verification
A corrupted demotion record causes no symptom while fixed mode is selected. It shows up at the first owner-demoting idle edge where two masters request: the grant then lands one edge later on the wrong bit. A stuck state register shows at once. It can leave the grant on while host mode is off, or leave the bus unparked at an idle edge with no requests. The bench drives long random runs with frequent idle edges and mode flips, so such faults show within a few cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter  int NREQ = 5,
    localparam int IW   = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req,
    input  logic            rr_mode,
    input  logic [IW-1:0]   last_idx,
    input  logic            last_vld,
    output logic [IW-1:0]   win_idx,
    output logic            win_vld
);
    logic [NREQ-1:0] demote;
    logic [NREQ-1:0] others;
    logic [NREQ-1:0] pool;

    for (genvar g = 0; g < NREQ; g++) begin : g_demote
        assign demote[g] = rr_mode && last_vld && (last_idx == IW'(g));
    end

    assign others  = req & ~demote;
    assign pool    = (|others) ? others : req;
    assign win_vld = |req;

    always_comb begin
        win_idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (pool[i]) win_idx = IW'(i);
        end
    end
endmodule

// File: rtl/arb_onehot.sv
module arb_onehot #(
    parameter  int NREQ = 5,
    localparam int IW   = $clog2(NREQ)
) (
    input  logic [IW-1:0]   idx,
    input  logic            en,
    output logic [NREQ-1:0] vec
);
    for (genvar g = 0; g < NREQ; g++) begin : g_bit
        assign vec[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
    parameter  int NREQ = 5,
    localparam int IW   = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic            bus_idle_i,
    input  logic            rr_mode_i,
    input  logic            host_en_i,
    output logic [NREQ-1:0] gnt_o
);
    import arb_pkg::*;

    arb_state_e    state_q, state_d;
    logic [IW-1:0] cur_q, cur_d;
    logic [IW-1:0] last_q, last_d;
    logic          lastv_q, lastv_d;
    logic [IW-1:0] win_idx;
    logic          win_vld;
    logic          gnt_en;

    arb_pick #(.NREQ(NREQ)) pick_i (
        .req      (req_i),
        .rr_mode  (rr_mode_i),
        .last_idx (last_q),
        .last_vld (lastv_q),
        .win_idx  (win_idx),
        .win_vld  (win_vld)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cur_q   <= '0;
            last_q  <= '0;
            lastv_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            lastv_q <= lastv_d;
        end
    end

    // transitions: Disable, Award, Park, Hold
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        last_d  = last_q;
        lastv_d = lastv_q;
        if (!host_en_i) begin
            state_d = ST_OFF;
        end else if (bus_idle_i) begin
            if (win_vld) begin
                state_d = ST_OWN;
                cur_d   = win_idx;
                last_d  = win_idx;
                lastv_d = 1'b1;
            end else begin
                state_d = ST_PARK;
                cur_d   = '0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OFF:  gnt_en = 1'b0;
            ST_PARK: gnt_en = 1'b1;
            ST_OWN:  gnt_en = 1'b1;
            default: gnt_en = 1'b0;
        endcase
    end

    arb_onehot #(.NREQ(NREQ)) dec_i (
        .idx (cur_q),
        .en  (gnt_en),
        .vec (gnt_o)
    );

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2
    fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_i && bus_idle_i && !rr_mode_i && (req_i != '0))
        |=> (gnt_o == $past(req_i & (~req_i + 1'b1))));

    // R4
    off_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en_i |=> (gnt_o == '0));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_i && !bus_idle_i) |=> $stable(gnt_o));

    // R7
    park_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_i && bus_idle_i && (req_i == '0)) |=> (gnt_o == NREQ'(1)));

    // R9
    gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_i && bus_idle_i && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));
endmodule

// File: tb/bus_grant_arbiter_tb.sv
module bus_grant_arbiter_tb_top;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         idle = 1'b0;
    logic         mode = 1'b0;
    logic         host = 1'b0;
    logic [N-1:0] gnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_state = 0;
    int m_cur = 0;
    int m_last = 0;
    bit m_vld = 1'b0;

    always #10 clk = ~clk;

    bus_grant_arbiter #(.NREQ(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .bus_idle_i (idle),
        .rr_mode_i  (mode),
        .host_en_i  (host),
        .gnt_o      (gnt)
    );

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int choose(input logic [N-1:0] r, input bit md);
        logic [N-1:0] rest = r;
        if (md && m_vld) rest[m_last] = 1'b0;
        return (rest != '0) ? lowest(rest) : lowest(r);
    endfunction

    function automatic logic [N-1:0] expect_gnt();
        if (m_state == 0) return '0;
        return N'(1) << m_cur;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        total++;
        if (gnt !== exp) begin
            bad++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input bit i, input bit md,
                        input bit h, input string tag);
        req = r; idle = i; mode = md; host = h;
        if (!h) m_state = 0;
        else if (i) begin
            if (r != '0) begin
                m_cur = choose(r, md); m_last = m_cur; m_vld = 1'b1; m_state = 2;
            end else begin
                m_cur = 0; m_state = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, expect_gnt());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: gnt=%b expected=finish", gnt);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check("R8 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", '0);

        step(5'b00000, 1, 0, 1, "R7 park");
        step(5'b10110, 1, 1, 1, "R8 first rr decision fixed");
        step(5'b10110, 1, 1, 1, "R3 owner demoted");
        step(5'b10110, 1, 1, 1, "R3 next rotation");
        step(5'b00000, 1, 1, 1, "R7 park in rr");
        step(5'b00110, 1, 1, 1, "R6 park kept pointer");
        step(5'b00100, 1, 1, 1, "R3 lone owner regranted");
        step(5'b00011, 0, 0, 1, "R5 hold on busy");
        step(5'b00011, 0, 1, 1, "R5 mode flip while busy");
        step(5'b00011, 1, 0, 1, "R2 fixed host wins");
        step(5'b11000, 1, 0, 1, "R2 fixed lowest");
        step(5'b11111, 1, 1, 0, "R4 disabled");
        step(5'b11111, 0, 1, 1, "R4 reenable waits idle");
        step(5'b11110, 1, 1, 1, "R3 after reenable");
        step(5'b10000, 1, 0, 1, "R9 only requester");
        step(5'b00000, 0, 0, 0, "R4 off while busy");
        step(5'b00000, 0, 0, 1, "R1 stays off busy");

        for (int k = 0; k < 3000; k++) begin
            step(N'($urandom % 32), ($urandom % 4) != 0, $urandom % 2,
                 ($urandom % 16) != 0, "R1 R3 random");
            if (!$onehot0(gnt)) begin
                total++; bad++;
                $display("FAIL R1: gnt=%b expected=onehot0", gnt);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule